// File: doc/BRIEF.md
# Video Lock Tracker with Free-Run Colour Substitution

This block sits after a sync processor in a video decoder. Once per video line it takes a raw lock indication and turns it into a debounced lock status. Lock is declared only after a programmable run of consecutive locked lines. It is dropped only after a programmable run of consecutive unlocked lines. The block also reports a present-state lock bit and a sticky lost-lock flag, which a status read clears.

The block also owns the outgoing luma and chroma sample stream. If a forced-output control is set, or if auto-default is enabled while the tracker is not locked, the live samples are replaced with programmed default colours, so that a stable flat picture is still produced. The two default chroma values come from one packed byte: the high nibble becomes Cr and the low nibble becomes Cb. The choice between live and default samples is made only at a line boundary, so a line is never split between the two sources.

The tracker is a four-state machine:
- TRK_UNLOCKED: idle without lock.
- TRK_ACQUIRE: counting locked lines.
- TRK_LOCKED: holding lock.
- TRK_RELEASE: counting unlocked lines while still reporting lock.

Transitions happen only on a line strobe:
- UNLOCKED goes to ACQUIRE, or straight to LOCKED when one line suffices, on a locked line.
- ACQUIRE goes to LOCKED when the count is reached, and back to UNLOCKED on any unlocked line.
- LOCKED goes to RELEASE, or straight to UNLOCKED when one line suffices, on an unlocked line.
- RELEASE goes to UNLOCKED when the count is reached, and back to LOCKED on any locked line.

Top module: `vlock_tracker`

## Requirements
- R1: After reset:
  - `locked`, `in_lock_now` and `lost_lock` are 0.
  - `out_is_default` is 1.
  - All sample outputs are 0.
- R2: The 3-bit `cil_code` selects how many consecutive locked lines are needed before `locked` rises. The codes map as follows: 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000. A line counts when `line_strobe` is high with `raw_lock` high.
- R3: An unlocked line (`line_strobe` high with `raw_lock` low) during acquisition restarts the count, so `locked` stays 0.
- R4: The 3-bit `col_code` uses the same mapping as R2. It sets how many consecutive unlocked lines drop `locked`. A locked line during that run restores full lock and restarts the run.
- R5: `locked` changes only at a clock edge where `line_strobe` is high. It becomes visible one cycle after that edge.
- R6: `in_lock_now` equals `raw_lock` delayed by one clock.
- R7: `lost_lock` sets at the same edge where `locked` falls, and holds until a cycle with `status_rd` high, which clears it. If a drop and a read occur in the same cycle, the flag ends up set.
- R8: With `force_def` high at a line strobe, the following line is default samples, whatever the lock state.
- R9: With `auto_def_en` high and the tracker unlocked after a line strobe, the following line is default samples. With `auto_def_en` and `force_def` both low, live samples pass even when unlocked.
- R10: The default samples are formed as follows. With `def_c` = 0x7C this gives Cr = 0x70 and Cb = 0xC0.
  - Y = {`def_y`, 2'b00}.
  - Cr = {`def_c`[7:4], 4'b0000}.
  - Cb = {`def_c`[3:0], 4'b0000}.
- R11: The live/default selection (`out_is_default`) changes only at a line strobe. A change of `force_def` in mid-line has no effect until the next strobe.
- R12: On live lines, each sample output equals the matching input one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_strobe | input | 1 | One-cycle pulse marking a line boundary |
| raw_lock | input | 1 | Undebounced lock flag from the sync processor |
| cil_code | input | 3 | Lines-into-lock code |
| col_code | input | 3 | Lines-out-of-lock code |
| force_def | input | 1 | Force default samples |
| auto_def_en | input | 1 | Enable default samples while unlocked |
| def_y | input | PIX_W-2 | Default luma, upper bits |
| def_c | input | PIX_W | Packed default chroma, Cr in the high half and Cb in the low half |
| status_rd | input | 1 | Status read strobe; clears the sticky flag |
| in_y | input | PIX_W | Live luma sample |
| in_cr | input | PIX_W | Live Cr sample |
| in_cb | input | PIX_W | Live Cb sample |
| locked | output | 1 | Debounced lock status |
| in_lock_now | output | 1 | Present lock state |
| lost_lock | output | 1 | Sticky loss-of-lock flag |
| out_y | output | PIX_W | Output luma |
| out_cr | output | PIX_W | Output Cr |
| out_cb | output | PIX_W | Output Cb |
| out_is_default | output | 1 | Current line carries default samples |

## Verification
Two functions can fall in the same cycle: a lock drop setting `lost_lock`, and a status read clearing it.

The bench first brings the tracker into lock with a one-line code. It then applies a line strobe with `raw_lock` low and `status_rd` high together. It expects `lost_lock` set afterwards, and clear only after a further read with no drop.

A second coincidence is a mid-line change of `force_def` beside a pending line strobe. It is judged by `out_is_default` holding until the strobe edge and switching exactly there.

// File: rtl/vlock_pkg.sv
package vlock_pkg;

    typedef enum logic [1:0] {
        TRK_UNLOCKED = 2'd0,
        TRK_ACQUIRE  = 2'd1,
        TRK_LOCKED   = 2'd2,
        TRK_RELEASE  = 2'd3
    } trk_state_t;

    // Number of consecutive lines selected by a 3-bit run-length code.
    function automatic int unsigned lines_for_code(input logic [2:0] code);
        int unsigned n;
        unique case (code)
            3'd0:    n = 1;
            3'd1:    n = 2;
            3'd2:    n = 5;
            3'd3:    n = 10;
            3'd4:    n = 100;
            3'd5:    n = 500;
            3'd6:    n = 1000;
            default: n = 100000;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/vlock_fsm.sv
module vlock_fsm
    import vlock_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_strobe,
    input  logic       raw_lock,
    input  logic [2:0] cil_code,
    input  logic [2:0] col_code,
    output logic       locked,
    output logic       lock_next,
    output logic       drop_evt
);

    trk_state_t       state, state_nxt;
    logic [CNT_W-1:0] run_cnt, run_cnt_nxt;
    logic [CNT_W-1:0] need_in, need_out;
    logic [CNT_W-1:0] run_inc;

    assign need_in  = CNT_W'(lines_for_code(cil_code));
    assign need_out = CNT_W'(lines_for_code(col_code));
    assign run_inc  = run_cnt + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TRK_UNLOCKED;
            run_cnt <= '0;
        end else begin
            state   <= state_nxt;
            run_cnt <= run_cnt_nxt;
        end
    end

    // Next-state logic: transitions happen only on a line strobe
    always_comb begin
        state_nxt   = state;
        run_cnt_nxt = run_cnt;
        if (line_strobe) begin
            unique case (state)
                TRK_UNLOCKED: begin
                    if (raw_lock) begin
                        if (need_in <= CNT_W'(1)) begin
                            state_nxt   = TRK_LOCKED;
                            run_cnt_nxt = '0;
                        end else begin
                            state_nxt   = TRK_ACQUIRE;
                            run_cnt_nxt = CNT_W'(1);
                        end
                    end
                end
                TRK_ACQUIRE: begin
                    if (!raw_lock) begin
                        state_nxt   = TRK_UNLOCKED;
                        run_cnt_nxt = '0;
                    end else if (run_inc >= need_in) begin
                        state_nxt   = TRK_LOCKED;
                        run_cnt_nxt = '0;
                    end else begin
                        run_cnt_nxt = run_inc;
                    end
                end
                TRK_LOCKED: begin
                    if (!raw_lock) begin
                        if (need_out <= CNT_W'(1)) begin
                            state_nxt   = TRK_UNLOCKED;
                            run_cnt_nxt = '0;
                        end else begin
                            state_nxt   = TRK_RELEASE;
                            run_cnt_nxt = CNT_W'(1);
                        end
                    end
                end
                TRK_RELEASE: begin
                    if (raw_lock) begin
                        state_nxt   = TRK_LOCKED;
                        run_cnt_nxt = '0;
                    end else if (run_inc >= need_out) begin
                        state_nxt   = TRK_UNLOCKED;
                        run_cnt_nxt = '0;
                    end else begin
                        run_cnt_nxt = run_inc;
                    end
                end
                default: begin
                    state_nxt   = TRK_UNLOCKED;
                    run_cnt_nxt = '0;
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        locked    = (state == TRK_LOCKED) || (state == TRK_RELEASE);
        lock_next = (state_nxt == TRK_LOCKED) || (state_nxt == TRK_RELEASE);
        drop_evt  = locked && (state_nxt == TRK_UNLOCKED);
    end

endmodule

// File: rtl/vlock_status.sv
module vlock_status (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_lock,
    input  logic drop_evt,
    input  logic status_rd,
    output logic in_lock_now,
    output logic lost_lock
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_lock_now <= 1'b0;
            lost_lock   <= 1'b0;
        end else begin
            in_lock_now <= raw_lock;
            if (drop_evt)
                lost_lock <= 1'b1;
            else if (status_rd)
                lost_lock <= 1'b0;
        end
    end

endmodule

// File: rtl/vlock_subst.sv
module vlock_subst #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             sub_req,
    input  logic [PIX_W-3:0] def_y,
    input  logic [PIX_W-1:0] def_c,
    input  logic [PIX_W-1:0] in_y,
    input  logic [PIX_W-1:0] in_cr,
    input  logic [PIX_W-1:0] in_cb,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_cr,
    output logic [PIX_W-1:0] out_cb,
    output logic             out_is_default
);

    localparam int HALF  = PIX_W / 2;
    localparam int N_CH  = 3;

    logic             sub_active;
    logic             sel;
    logic [PIX_W-1:0] live_s [N_CH];
    logic [PIX_W-1:0] dflt_s [N_CH];
    logic [PIX_W-1:0] pix_q  [N_CH];

    assign sel = line_strobe ? sub_req : sub_active;

    assign live_s[0] = in_y;
    assign live_s[1] = in_cr;
    assign live_s[2] = in_cb;

    assign dflt_s[0] = {def_y, 2'b00};
    assign dflt_s[1] = {def_c[PIX_W-1:HALF], {HALF{1'b0}}};
    assign dflt_s[2] = {def_c[HALF-1:0], {(PIX_W-HALF){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sub_active <= 1'b1;
        else
            sub_active <= sel;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pix_q[ch] <= '0;
            else
                pix_q[ch] <= sel ? dflt_s[ch] : live_s[ch];
        end
    end

    assign out_y          = pix_q[0];
    assign out_cr         = pix_q[1];
    assign out_cb         = pix_q[2];
    assign out_is_default = sub_active;

endmodule

// File: rtl/vlock_tracker.sv
module vlock_tracker #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             raw_lock,
    input  logic [2:0]       cil_code,
    input  logic [2:0]       col_code,
    input  logic             force_def,
    input  logic             auto_def_en,
    input  logic [PIX_W-3:0] def_y,
    input  logic [PIX_W-1:0] def_c,
    input  logic             status_rd,
    input  logic [PIX_W-1:0] in_y,
    input  logic [PIX_W-1:0] in_cr,
    input  logic [PIX_W-1:0] in_cb,
    output logic             locked,
    output logic             in_lock_now,
    output logic             lost_lock,
    output logic [PIX_W-1:0] out_y,
    output logic [PIX_W-1:0] out_cr,
    output logic [PIX_W-1:0] out_cb,
    output logic             out_is_default
);

    logic lock_next;
    logic drop_evt;
    logic sub_req;

    vlock_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_strobe (line_strobe),
        .raw_lock    (raw_lock),
        .cil_code    (cil_code),
        .col_code    (col_code),
        .locked      (locked),
        .lock_next   (lock_next),
        .drop_evt    (drop_evt)
    );

    vlock_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_lock    (raw_lock),
        .drop_evt    (drop_evt),
        .status_rd   (status_rd),
        .in_lock_now (in_lock_now),
        .lost_lock   (lost_lock)
    );

    assign sub_req = force_def || (auto_def_en && !lock_next);

    vlock_subst #(.PIX_W(PIX_W)) u_subst (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_strobe    (line_strobe),
        .sub_req        (sub_req),
        .def_y          (def_y),
        .def_c          (def_c),
        .in_y           (in_y),
        .in_cr          (in_cr),
        .in_cb          (in_cb),
        .out_y          (out_y),
        .out_cr         (out_cr),
        .out_cb         (out_cb),
        .out_is_default (out_is_default)
    );

endmodule

// File: rtl/vlock_tracker_chk.sv
module vlock_tracker_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_strobe,
    input logic             raw_lock,
    input logic             force_def,
    input logic             auto_def_en,
    input logic             status_rd,
    input logic             locked,
    input logic             in_lock_now,
    input logic             lost_lock,
    input logic [PIX_W-1:0] out_y,
    input logic [PIX_W-1:0] out_cr,
    input logic [PIX_W-1:0] out_cb,
    input logic             out_is_default
);

    localparam int HALF = PIX_W / 2;

    assert_lock_rise_on_locked_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(line_strobe && raw_lock));

    assert_lock_fall_on_unlocked_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(line_strobe && !raw_lock));

    assert_lock_only_at_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> $stable(locked));

    assert_present_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (in_lock_now == $past(raw_lock)));

    assert_lost_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> lost_lock);

    assert_lost_only_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_lock) |-> $fell(locked));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !(line_strobe && !raw_lock)) |=> !lost_lock);

    assert_force_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && force_def) |=> out_is_default);

    assert_no_auto_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !force_def && !auto_def_en) |=> !out_is_default);

    assert_default_format_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_default |-> (out_y[1:0] == 2'b00 && out_cr[HALF-1:0] == '0 && out_cb[HALF-1:0] == '0));

    assert_switch_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> $stable(out_is_default));

endmodule

bind vlock_tracker vlock_tracker_chk #(.PIX_W(PIX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_strobe    (line_strobe),
    .raw_lock       (raw_lock),
    .force_def      (force_def),
    .auto_def_en    (auto_def_en),
    .status_rd      (status_rd),
    .locked         (locked),
    .in_lock_now    (in_lock_now),
    .lost_lock      (lost_lock),
    .out_y          (out_y),
    .out_cr         (out_cr),
    .out_cb         (out_cb),
    .out_is_default (out_is_default)
);

// File: tb/vlock_tracker_test.sv
module vlock_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_strobe, raw_lock, force_def, auto_def_en, status_rd;
    logic [2:0] cil_code, col_code;
    logic [5:0] def_y;
    logic [7:0] def_c;
    logic [7:0] in_y, in_cr, in_cb;
    logic       locked, in_lock_now, lost_lock, out_is_default;
    logic [7:0] out_y, out_cr, out_cb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    vlock_tracker uut (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .raw_lock(raw_lock),
        .cil_code(cil_code), .col_code(col_code), .force_def(force_def),
        .auto_def_en(auto_def_en), .def_y(def_y), .def_c(def_c),
        .status_rd(status_rd), .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
        .locked(locked), .in_lock_now(in_lock_now), .lost_lock(lost_lock),
        .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb),
        .out_is_default(out_is_default)
    );

    // Vector: [15]strobe [14]raw [13]force [12]auto [11]rd
    //         [10]exp_locked [9]exp_lost [8]exp_default [7:0]sample
    localparam int NV = 20;
    localparam logic [15:0] VEC [NV] = '{
        16'b0_1_0_1_0_0_0_1_00010001,
        16'b1_1_0_1_0_0_0_1_00100010,
        16'b0_1_0_1_0_0_0_1_00110011,
        16'b1_1_0_1_0_1_0_0_01000100,
        16'b0_0_0_1_0_1_0_0_01010101,
        16'b1_0_0_1_0_1_0_0_01100110,
        16'b1_1_0_1_0_1_0_0_01110111,
        16'b1_0_0_1_0_1_0_0_10001000,
        16'b1_0_0_1_0_0_1_1_10011001,
        16'b0_0_0_1_1_0_0_1_10101010,
        16'b1_1_0_1_0_0_0_1_10111011,
        16'b1_0_0_1_0_0_0_1_11001100,
        16'b1_1_0_1_0_0_0_1_11011101,
        16'b1_1_0_1_0_1_0_0_11101110,
        16'b0_1_1_1_0_1_0_0_00001111,
        16'b1_1_1_1_0_1_0_1_00011110,
        16'b1_1_0_1_0_1_0_0_00101101,
        16'b1_0_0_0_0_1_0_0_00111100,
        16'b1_0_0_0_0_0_1_0_01001011,
        16'b1_0_0_0_1_0_0_0_01011010
    };

    function automatic int bench_lines(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 5;
            3'd3: return 10;
            3'd4: return 100;
            3'd5: return 500;
            3'd6: return 1000;
            default: return 100000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic r, input logic f, input logic a,
                         input logic d, input logic [7:0] pix);
        line_strobe = s; raw_lock = r; force_def = f; auto_def_en = a; status_rd = d;
        in_y = pix; in_cr = ~pix; in_cb = pix + 8'd1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line_strobe = 0; raw_lock = 0; force_def = 0; auto_def_en = 1; status_rd = 0;
        in_y = 0; in_cr = 0; in_cb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_sample(input string req, input logic isdef, input logic [7:0] pix);
        if (isdef) begin
            chk(req, out_y,  {def_y, 2'b00});
            chk(req, out_cr, {def_c[7:4], 4'h0});
            chk(req, out_cb, {def_c[3:0], 4'h0});
        end else begin
            chk(req, out_y,  pix);
            chk(req, out_cr, ~pix);
            chk(req, out_cb, pix + 8'd1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        def_y = 6'h2A; def_c = 8'h7C;
        cil_code = 3'd1; col_code = 3'd1;
        do_reset();

        // R1 reset state
        chk("R1 locked",  {7'd0, locked}, 8'd0);
        chk("R1 lost",    {7'd0, lost_lock}, 8'd0);
        chk("R1 present", {7'd0, in_lock_now}, 8'd0);
        chk("R1 default", {7'd0, out_is_default}, 8'd1);
        chk("R1 y",  out_y,  8'd0);
        chk("R1 cr", out_cr, 8'd0);
        chk("R1 cb", out_cb, 8'd0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            drive(v[15], v[14], v[13], v[12], v[11], v[7:0]);
            chk($sformatf("R2/R3/R4/R5 locked v%0d", i), {7'd0, locked}, {7'd0, v[10]});
            chk($sformatf("R7 lost v%0d", i), {7'd0, lost_lock}, {7'd0, v[9]});
            chk($sformatf("R6 present v%0d", i), {7'd0, in_lock_now}, {7'd0, v[14]});
            chk($sformatf("R8/R9/R11 default v%0d", i), {7'd0, out_is_default}, {7'd0, v[8]});
            check_sample($sformatf("R10/R12 sample v%0d", i), v[8], v[7:0]);
        end

        // R10 other default values under force
        def_y = 6'h3F; def_c = 8'hA5;
        drive(1, 1, 1, 0, 0, 8'h12);
        chk("R10 y",  out_y,  8'hFC);
        chk("R10 cr", out_cr, 8'hA0);
        chk("R10 cb", out_cb, 8'h50);
        def_y = 6'h2A; def_c = 8'h7C;
        drive(0, 1, 1, 0, 0, 8'h34);
        chk("R10 blue cr", out_cr, 8'h70);
        chk("R10 blue cb", out_cb, 8'hC0);

        // R7 drop and read in the same cycle: set wins
        do_reset();
        cil_code = 3'd0; col_code = 3'd0;
        drive(1, 1, 0, 1, 0, 8'h01);
        chk("R2 code0 lock", {7'd0, locked}, 8'd1);
        drive(1, 0, 0, 1, 1, 8'h02);
        chk("R7 simul locked", {7'd0, locked}, 8'd0);
        chk("R7 simul set wins", {7'd0, lost_lock}, 8'd1);
        drive(0, 0, 0, 1, 0, 8'h03);
        chk("R7 sticky", {7'd0, lost_lock}, 8'd1);
        drive(0, 0, 0, 1, 1, 8'h04);
        chk("R7 read clears", {7'd0, lost_lock}, 8'd0);

        // R2 / R4 run lengths for several codes
        for (int k = 0; k < 4; k++) begin
            logic [2:0] code;
            int n;
            code = (k == 0) ? 3'd0 : (k == 1) ? 3'd2 : (k == 2) ? 3'd3 : 3'd1;
            n = bench_lines(code);
            do_reset();
            cil_code = code; col_code = code;
            for (int j = 1; j <= n; j++) begin
                drive(1, 1, 0, 1, 0, 8'h40);
                chk($sformatf("R2 code%0d line%0d", code, j), {7'd0, locked}, {7'd0, (j >= n)});
            end
            for (int j = 1; j <= n; j++) begin
                drive(1, 0, 0, 1, 0, 8'h41);
                chk($sformatf("R4 code%0d line%0d", code, j), {7'd0, locked}, {7'd0, (j < n)});
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule